// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

The block takes in interrupt messages for a core, one message at most per cycle. Each message carries an 8-bit vector and a flag that says whether it is level or edge triggered. The block keeps three bit arrays with one bit per vector: requests waiting to be served, vectors in service, and the trigger kind of each request. It tracks two vectors at all times. The first is the highest vector that is waiting. The second is the highest vector in service. From these it decides whether the core may be interrupted.

An interrupt is offered only if three conditions hold together:
- the core's interrupt enable is set;
- the waiting vector is above the in-service vector;
- the waiting vector's priority class (bits 7:4) is above the class of the task priority.

When the core acknowledges an offered interrupt, that vector leaves the waiting set and joins the in-service set. On the following cycle the block returns the vector to the core. An end-of-interrupt strobe retires the highest in-service vector. This lets a higher vector preempt a lower one, and the lower one resumes when the higher one is retired.

Top module: `vec_irq_arbiter`

## Requirements
- R1: After reset all three arrays are empty. `irq`, `irq_vector`, `inservice_vector`, `pend_level` and `taken` are all 0.
- R2: A message with `msg_valid`=1 sets the request bit of `msg_vector`. From the next cycle, `irq_vector` is the highest vector with its request bit set, or 0 when no bit is set.
- R3: A message whose vector is already waiting changes nothing. In particular, the stored trigger kind of that vector keeps its old value.
- R4: When a message sets a new request bit, the trigger bit of that vector is set to `msg_level` (1 = level, 0 = edge). `pend_level` shows the trigger bit of the vector on `irq_vector`.
- R5: `irq` is 1 exactly when all of these hold: `core_ie`=1, `irq_vector` > `inservice_vector`, and `irq_vector[7:4]` > `task_prio[7:4]`.
- R6: Raising `ack` while `irq`=1 moves the vector on `irq_vector` from waiting to in service. On the next cycle `taken`=1, `taken_vector` holds that vector, and `inservice_vector` equals it.
- R7: Raising `ack` while `irq`=0 has no effect: both tracked vectors stay the same and `taken` stays 0.
- R8: `eoi` clears the highest set in-service bit. From the next cycle `inservice_vector` is the next highest set bit, or 0 if none is left. An `eoi` with no bit in service has no effect.
- R9: A message and an accepted acknowledge in the same cycle both take effect, and the new maximum includes the new request. If the message names the vector being acknowledged, which was waiting before the edge, the message is dropped.
- R10: `inservice_vector` is always the highest in-service vector. While it is higher than every waiting vector, `irq` stays 0, and it becomes 1 again once `eoi` retires that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An interrupt message is present this cycle |
| msg_vector | input | 8 | Vector of the message |
| msg_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| task_prio | input | 8 | Task priority; only bits 7:4 are compared |
| core_ie | input | 1 | Core interrupt enable |
| ack | input | 1 | Core takes the offered interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| irq | output | 1 | An interrupt may be taken |
| irq_vector | output | 8 | Highest waiting vector (0 if none) |
| inservice_vector | output | 8 | Highest in-service vector (0 if none) |
| pend_level | output | 1 | Trigger bit of the vector on `irq_vector` |
| taken | output | 1 | One-cycle pulse after an accepted acknowledge |
| taken_vector | output | 8 | Vector returned by the last accepted acknowledge |

## Verification
The properties assume that `ack` and `eoi` are single-cycle strobes. They also assume that an acknowledge counts only when `irq` is high in the same cycle, and that `eoi` is never used to retire a vector that is not the highest in service. The stimulus drives every strobe for exactly one cycle, and it changes `task_prio` and `core_ie` only between steps. Acknowledges are sometimes deliberately sent while `irq` is low, to show that they are ignored. Merged cases, where a message arrives together with an acknowledge, use vectors that are already waiting and vectors that are not.

// File: rtl/via_pkg.sv
package via_pkg;
  // Priority class comparison: upper bits of a vector above the upper bits of a threshold.
  function automatic logic class_above(input int unsigned vec, input int unsigned thr,
                                       input int unsigned shift);
    return (vec >> shift) > (thr >> shift);
  endfunction

  // One-hot mask of a vector index in an array of width n (n <= 1024).
  function automatic logic [1023:0] vec_mask(input int unsigned idx);
    logic [1023:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/via_prio_enc.sv
module via_prio_enc #(
  parameter int N = 256,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] bits_in,
  output logic [W-1:0] top_idx
);
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_in[i]) top_idx = W'(i);
    end
  end
endmodule

// File: rtl/via_deliver.sv
module via_deliver #(
  parameter int VW    = 8,
  parameter int CLS_W = 4
) (
  input  logic [VW-1:0] pend_vec,
  input  logic [VW-1:0] serv_vec,
  input  logic [VW-1:0] task_prio,
  input  logic          core_ie,
  output logic          deliver
);
  import via_pkg::*;
  localparam int SHIFT = VW - CLS_W;

  always_comb begin
    deliver = core_ie && (pend_vec > serv_vec) &&
              class_above(int'(pend_vec), int'(task_prio), SHIFT);
  end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter #(
  parameter int NVEC  = 256,
  parameter int CLS_W = 4,
  localparam int VW   = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_valid,
  input  logic [VW-1:0] msg_vector,
  input  logic          msg_level,
  input  logic [VW-1:0] task_prio,
  input  logic          core_ie,
  input  logic          ack,
  input  logic          eoi,
  output logic          irq,
  output logic [VW-1:0] irq_vector,
  output logic [VW-1:0] inservice_vector,
  output logic          pend_level,
  output logic          taken,
  output logic [VW-1:0] taken_vector
);
  import via_pkg::*;

  logic [NVEC-1:0] req_q, isr_q, trig_q;
  logic [NVEC-1:0] ack_mask, msg_mask, eoi_mask;
  logic [VW-1:0]   pend_vec, serv_vec;
  logic            accept;   // acknowledge that moves a vector into service
  logic            msg_new;  // message that creates a new request
  logic            deliver;
  logic            taken_q;
  logic [VW-1:0]   taken_vec_q;

  via_prio_enc #(.N(NVEC)) u_pend_enc (.bits_in(req_q), .top_idx(pend_vec));
  via_prio_enc #(.N(NVEC)) u_serv_enc (.bits_in(isr_q), .top_idx(serv_vec));

  via_deliver #(.VW(VW), .CLS_W(CLS_W)) u_deliver (
    .pend_vec (pend_vec),
    .serv_vec (serv_vec),
    .task_prio(task_prio),
    .core_ie  (core_ie),
    .deliver  (deliver)
  );

  always_comb begin
    accept   = ack && deliver;
    msg_new  = msg_valid && !req_q[msg_vector];
    ack_mask = accept  ? NVEC'(vec_mask(int'(pend_vec)))   : '0;
    msg_mask = msg_new ? NVEC'(vec_mask(int'(msg_vector))) : '0;
    eoi_mask = eoi     ? NVEC'(vec_mask(int'(serv_vec)))   : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= '0;
      isr_q       <= '0;
      trig_q      <= '0;
      taken_q     <= 1'b0;
      taken_vec_q <= '0;
    end else begin
      req_q   <= (req_q & ~ack_mask) | msg_mask;
      isr_q   <= (isr_q & ~eoi_mask) | ack_mask;
      trig_q  <= msg_level ? (trig_q | msg_mask) : (trig_q & ~msg_mask);
      taken_q <= accept;
      if (accept) taken_vec_q <= pend_vec;
    end
  end

  assign irq              = deliver;
  assign irq_vector       = pend_vec;
  assign inservice_vector = serv_vec;
  assign pend_level       = trig_q[pend_vec];
  assign taken            = taken_q;
  assign taken_vector     = taken_vec_q;
endmodule

// File: rtl/vec_irq_arbiter_chk.sv
module vec_irq_arbiter_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic [VW-1:0] msg_vector,
  input logic          core_ie,
  input logic          ack,
  input logic          eoi,
  input logic          accept,
  input logic          irq,
  input logic [VW-1:0] irq_vector,
  input logic [VW-1:0] inservice_vector,
  input logic          taken,
  input logic [VW-1:0] taken_vector
);
  // R5: an offered interrupt needs the enable
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> core_ie);

  // R5: an offered interrupt is above the one in service
  a_r5_irq_above_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vector > inservice_vector));

  // R6: an accepted acknowledge returns the offered vector and puts it in service
  a_r6_return_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (taken && taken_vector == $past(irq_vector)
                      && inservice_vector == $past(irq_vector)));

  // R7: no returned vector without an accepted acknowledge
  a_r7_no_spurious_take: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !taken);

  // R2: after a message the waiting maximum is at least that vector
  a_r2_pending_covers_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !ack) |=> (irq_vector >= $past(msg_vector)));

  // R8: end of interrupt lowers the in-service vector
  a_r8_eoi_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && inservice_vector != '0) |=> (inservice_vector < $past(inservice_vector)));
endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
  .core_ie(core_ie), .ack(ack), .eoi(eoi), .accept(accept), .irq(irq),
  .irq_vector(irq_vector), .inservice_vector(inservice_vector),
  .taken(taken), .taken_vector(taken_vector)
);

// File: tb/vec_irq_arbiter_bench.sv
`timescale 1ns/1ps
module vec_irq_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_valid, msg_level, core_ie, ack, eoi;
  logic [7:0] msg_vector, task_prio;
  logic       irq, pend_level, taken;
  logic [7:0] irq_vector, inservice_vector, taken_vector;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vec_irq_arbiter u_vec_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_level(msg_level), .task_prio(task_prio), .core_ie(core_ie), .ack(ack),
    .eoi(eoi), .irq(irq), .irq_vector(irq_vector),
    .inservice_vector(inservice_vector), .pend_level(pend_level),
    .taken(taken), .taken_vector(taken_vector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Fields: mv vec lvl tpr ie ack eoi | irq pv sv plvl tk tv
  localparam int NROW = 15;
  localparam logic [47:0] TBL [NROW] = '{
    {1'b1,8'h45,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h45,8'h00,1'b0,1'b0,8'h00}, // R2 R4 R5
    {1'b1,8'h30,1'b1,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h45,8'h00,1'b0,1'b0,8'h00}, // R2
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b1,1'b0, 1'b0,8'h30,8'h45,1'b1,1'b1,8'h45}, // R6 R4
    {1'b1,8'h80,1'b1,8'h00,1'b1,1'b0,1'b0, 1'b1,8'h80,8'h45,1'b1,1'b0,8'h00}, // R10 R4
    {1'b0,8'h00,1'b0,8'h80,1'b1,1'b0,1'b0, 1'b0,8'h80,8'h45,1'b1,1'b0,8'h00}, // R5 class equal
    {1'b0,8'h00,1'b0,8'h7F,1'b1,1'b0,1'b0, 1'b1,8'h80,8'h45,1'b1,1'b0,8'h00}, // R5 low bits ignored
    {1'b0,8'h00,1'b0,8'h7F,1'b0,1'b0,1'b0, 1'b0,8'h80,8'h45,1'b1,1'b0,8'h00}, // R5 enable off
    {1'b0,8'h00,1'b0,8'h7F,1'b0,1'b1,1'b0, 1'b0,8'h80,8'h45,1'b1,1'b0,8'h00}, // R7
    {1'b0,8'h00,1'b0,8'h7F,1'b1,1'b1,1'b0, 1'b0,8'h30,8'h80,1'b1,1'b1,8'h80}, // R6 R10
    {1'b0,8'h00,1'b0,8'h7F,1'b1,1'b0,1'b1, 1'b0,8'h30,8'h45,1'b1,1'b0,8'h00}, // R8
    {1'b0,8'h00,1'b0,8'h20,1'b1,1'b0,1'b1, 1'b1,8'h30,8'h00,1'b1,1'b0,8'h00}, // R8 R10
    {1'b0,8'h00,1'b0,8'h20,1'b1,1'b0,1'b1, 1'b1,8'h30,8'h00,1'b1,1'b0,8'h00}, // R8 empty
    {1'b1,8'h30,1'b0,8'h20,1'b1,1'b0,1'b0, 1'b1,8'h30,8'h00,1'b1,1'b0,8'h00}, // R3
    {1'b1,8'h31,1'b0,8'h20,1'b1,1'b1,1'b0, 1'b1,8'h31,8'h30,1'b0,1'b1,8'h30}, // R9 merge
    {1'b1,8'h31,1'b1,8'h20,1'b1,1'b1,1'b0, 1'b0,8'h00,8'h31,1'b0,1'b1,8'h31}  // R9 drop
  };

  task automatic step(input logic mv, input logic [7:0] v, input logic lv,
                      input logic [7:0] tp, input logic ie, input logic ak, input logic eo);
    @(negedge clk);
    msg_valid = mv; msg_vector = v; msg_level = lv;
    task_prio = tp; core_ie = ie; ack = ak; eoi = eo;
    @(posedge clk);
    #1;
    msg_valid = 1'b0; ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    msg_valid = 1'b0; msg_vector = '0; msg_level = 1'b0;
    task_prio = '0; core_ie = 1'b1; ack = 1'b0; eoi = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state;
    chk("R1 irq", irq, 0);
    chk("R1 irq_vector", irq_vector, 0);
    chk("R1 inservice_vector", inservice_vector, 0);
    chk("R1 pend_level", pend_level, 0);
    chk("R1 taken", taken, 0);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check_reset_state();

    for (int r = 0; r < NROW; r++) begin
      logic [47:0] e;
      e = TBL[r];
      step(e[47], e[46:39], e[38], e[37:30], e[29], e[28], e[27]);
      chk($sformatf("R5 row %0d irq", r), irq, e[26]);
      chk($sformatf("R2 row %0d irq_vector", r), irq_vector, e[25:18]);
      chk($sformatf("R10 row %0d inservice_vector", r), inservice_vector, e[17:10]);
      chk($sformatf("R4 row %0d pend_level", r), pend_level, e[9]);
      chk($sformatf("R6 row %0d taken", r), taken, e[8]);
      if (e[8]) chk($sformatf("R6 row %0d taken_vector", r), taken_vector, e[7:0]);
    end

    // R1: reset in the middle of activity empties everything
    do_reset();
    check_reset_state();

    // R4 R5: vector 0 is stored but never offered
    step(1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R4 vector0 pend_level", pend_level, 1);
    chk("R5 vector0 irq", irq, 0);
    chk("R2 vector0 irq_vector", irq_vector, 0);

    // R5: top vector against top and next class
    step(1'b1, 8'hFF, 1'b0, 8'hEF, 1'b1, 1'b0, 1'b0);
    chk("R2 top irq_vector", irq_vector, 8'hFF);
    chk("R5 top irq", irq, 1);
    chk("R4 top pend_level", pend_level, 0);
    step(1'b0, 8'h00, 1'b0, 8'hF0, 1'b1, 1'b0, 1'b0);
    chk("R5 top class equal irq", irq, 0);

    // R6 R8: take FF then retire it
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R6 top taken_vector", taken_vector, 8'hFF);
    chk("R6 top inservice_vector", inservice_vector, 8'hFF);
    chk("R7 after take irq", irq, 0);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    chk("R8 top retired", inservice_vector, 0);
    chk("R6 taken pulse ends", taken, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule